// File: doc/BRIEF.md
# Hart Debug-Mode Control and Status Unit

This unit keeps the debug-mode state of a single hart. It has three CSRs: a debug control/status word, a resume-PC register and a bank of debugger scratch registers. The unit decides when the hart stops and enters debug mode, and it records the reason. On entry it saves the PC that execution should resume at, together with the current privilege level. When the hart executes a debug-return instruction, the unit gives back the saved PC and privilege as a one-cycle redirect.

The pipeline feeds the unit with strobes: a halt request, a breakpoint instruction executed, an instruction retired and a debug-return executed. It also supplies the current resume PC and privilege. A single-step bit stops the hart again after the next retired instruction. Three per-privilege enable bits decide whether a breakpoint instruction stops the hart. All outputs are registered. CSR read data appears one cycle after the address is presented.

Top module: `hart_debug_csr_unit`

## Requirements
- R1: After reset the unit is out of debug mode and the redirect valid output is low. The control word reads 0x4000_0003 (version 4, cause 0, privilege machine). The resume-PC and scratch registers read 0.
- R2: CSR reads are registered. The value for the address presented in one cycle appears on the read data after the next clock edge. Address 0x7B0 returns the control word, 0x7B1 the resume PC and 0x7B2 upward the scratch registers. Any other address returns 0.
- R3: The control word has these fields: version in [31:28], reads 4; machine breakpoint enable in [15]; supervisor breakpoint enable in [13]; user breakpoint enable in [12]; step interrupt enable in [11]; stop counter in [10]; stop timer in [9]; cause in [8:6]; privilege-modify enable in [4]; NMI pending in [3], reads 0; step in [2]; privilege in [1:0]. A write changes only bits 15, 13:9, 4, 2 and 1:0. Version, cause and NMI pending ignore writes, and every other bit reads 0. Writing all ones with cause 0 reads back 0x4000_BE17.
- R4: A write of privilege value 2 to bits [1:0] is stored as 3 (machine). Values 0 (user), 1 (supervisor) and 3 are stored unchanged.
- R5: Outside debug mode, a halt request enters debug mode on the next edge. The cause becomes 3, the resume PC takes the PC input and the privilege field takes the privilege input.
- R6: Outside debug mode, a breakpoint strobe enters debug mode with cause 1 only when the enable bit for the current privilege is set. With that bit clear, the unit stays out of debug mode.
- R7: When several entry reasons occur in the same cycle, the recorded cause follows the priority breakpoint (1), then halt request (3), then step (4).
- R8: With the step bit set, the first retired instruction outside debug mode enters debug mode with cause 4 and captures the PC input.
- R9: In debug mode, halt request, breakpoint and retire strobes do not change the cause, the resume PC or the privilege field.
- R10: The resume-PC and scratch registers accept CSR writes only in debug mode. Outside debug mode such writes are ignored.
- R11: A debug-return strobe in debug mode leaves debug mode on the next edge. It raises redirect valid for exactly one cycle, with the resume PC as redirect address and the privilege field as restored privilege. A debug-return strobe outside debug mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_we_i | input | 1 | CSR write enable |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | Registered CSR read data |
| pc_i | input | 32 | PC to resume at if debug mode is entered this cycle |
| priv_i | input | 2 | Current privilege level |
| halt_req_i | input | 1 | Halt request from the debugger |
| brk_exec_i | input | 1 | Breakpoint instruction executed |
| retire_i | input | 1 | Instruction retired |
| dbg_return_i | input | 1 | Debug-return instruction executed |
| dbg_mode_o | output | 1 | Hart is in debug mode |
| redirect_valid_o | output | 1 | One-cycle pulse: fetch from redirect_pc_o |
| redirect_pc_o | output | 32 | Resume address on leaving debug mode |
| restore_priv_o | output | 2 | Privilege to resume in |

## Verification
The assertions assume one thing about the pipeline: it never raises a retire or debug-return strobe that conflicts with a debug-mode entry in the same cycle. They also assume the privilege input stays in the legal range, apart from the deliberate reserved value used to test legalisation. The bench drives each strobe as a single-cycle pulse on the falling edge and returns every input to idle before the next scenario. Debug-return is only ever issued while the bench expects the hart to be halted, except in the one case that checks it is ignored.

// File: rtl/dbgcsr_pkg.sv
package dbgcsr_pkg;
  localparam logic [11:0] ADDR_CTRL = 12'h7B0;
  localparam logic [11:0] ADDR_RPC  = 12'h7B1;
  localparam logic [11:0] ADDR_SCR0 = 12'h7B2;
  localparam logic [3:0]  DBG_VERSION = 4'd4;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_BRK     = 3'd1,
    CAUSE_TRIG    = 3'd2,
    CAUSE_HALT    = 3'd3,
    CAUSE_STEP    = 3'd4,
    CAUSE_RSTHALT = 3'd5
  } cause_e;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  typedef struct packed {
    logic   brk_m;
    logic   brk_s;
    logic   brk_u;
    logic   step_irq;
    logic   stop_cnt;
    logic   stop_tm;
    logic   mprv_en;
    logic   step;
    cause_e cause;
    priv_e  prv;
  } ctrl_t;

  function automatic priv_e legal_priv(input logic [1:0] p);
    return (p == 2'd2) ? PRIV_M : priv_e'(p);
  endfunction
endpackage

// File: rtl/dbg_entry_arb.sv
module dbg_entry_arb
  import dbgcsr_pkg::*;
(
  input  logic   in_debug_i,
  input  priv_e  priv_i,
  input  logic   brk_i,
  input  logic   halt_i,
  input  logic   retire_i,
  input  logic   step_en_i,
  input  logic   brk_en_m_i,
  input  logic   brk_en_s_i,
  input  logic   brk_en_u_i,
  output logic   enter_o,
  output cause_e cause_o
);
  logic brk_allowed;

  always_comb begin
    unique case (priv_i)
      PRIV_U:  brk_allowed = brk_en_u_i;
      PRIV_S:  brk_allowed = brk_en_s_i;
      default: brk_allowed = brk_en_m_i;
    endcase
  end

  always_comb begin
    enter_o = 1'b0;
    cause_o = CAUSE_NONE;
    if (!in_debug_i) begin
      if (brk_i && brk_allowed) begin
        enter_o = 1'b1;
        cause_o = CAUSE_BRK;
      end else if (halt_i) begin
        enter_o = 1'b1;
        cause_o = CAUSE_HALT;
      end else if (step_en_i && retire_i) begin
        enter_o = 1'b1;
        cause_o = CAUSE_STEP;
      end
    end
  end
endmodule

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import dbgcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            in_debug_i,
  input  logic            wr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            enter_i,
  input  cause_e          cause_i,
  input  logic [1:0]      priv_i,
  output ctrl_t           ctrl_o,
  output logic [XLEN-1:0] word_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q       <= '0;
      ctrl_q.cause <= CAUSE_NONE;
      ctrl_q.prv   <= PRIV_M;
    end else begin
      if (wr_i) begin
        ctrl_q.brk_m    <= wdata_i[15];
        ctrl_q.brk_s    <= wdata_i[13];
        ctrl_q.brk_u    <= wdata_i[12];
        ctrl_q.step_irq <= wdata_i[11];
        ctrl_q.stop_cnt <= wdata_i[10];
        ctrl_q.stop_tm  <= wdata_i[9];
        ctrl_q.mprv_en  <= wdata_i[4];
        ctrl_q.step     <= wdata_i[2];
        ctrl_q.prv      <= legal_priv(wdata_i[1:0]);
      end
      if (enter_i) begin
        ctrl_q.cause <= cause_i;
        ctrl_q.prv   <= legal_priv(priv_i);
      end
    end
  end

  always_comb begin
    word_o            = '0;
    word_o[XLEN-1 -: 4] = DBG_VERSION;
    word_o[15]        = ctrl_q.brk_m;
    word_o[13]        = ctrl_q.brk_s;
    word_o[12]        = ctrl_q.brk_u;
    word_o[11]        = ctrl_q.step_irq;
    word_o[10]        = ctrl_q.stop_cnt;
    word_o[9]         = ctrl_q.stop_tm;
    word_o[8:6]       = ctrl_q.cause;
    word_o[4]         = ctrl_q.mprv_en;
    word_o[3]         = 1'b0;
    word_o[2]         = ctrl_q.step;
    word_o[1:0]       = ctrl_q.prv;
  end

  assign ctrl_o = ctrl_q;

  assert_cause_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_debug_i && !wr_i) |=> ($stable(ctrl_q.cause) && $stable(ctrl_q.prv)));

  assert_prv_legal_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    ctrl_q.prv != PRIV_RSV);
endmodule

// File: rtl/dbg_pc_store.sv
module dbg_pc_store
  import dbgcsr_pkg::*;
#(
  parameter int XLEN          = 32,
  parameter int SCRATCH_COUNT = 1
) (
  input  logic                               clk_i,
  input  logic                               rst_i,
  input  logic                               in_debug_i,
  input  logic                               enter_i,
  input  logic [XLEN-1:0]                    pc_i,
  input  logic                               we_i,
  input  logic [11:0]                        addr_i,
  input  logic [XLEN-1:0]                    wdata_i,
  output logic [XLEN-1:0]                    rpc_o,
  output logic [SCRATCH_COUNT-1:0][XLEN-1:0] scratch_o
);
  logic [XLEN-1:0] rpc_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rpc_q <= '0;
    end else if (enter_i) begin
      rpc_q <= pc_i;
    end else if (we_i && in_debug_i && addr_i == ADDR_RPC) begin
      rpc_q <= wdata_i;
    end
  end

  for (genvar g = 0; g < SCRATCH_COUNT; g++) begin : g_scratch
    logic [XLEN-1:0] scr_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        scr_q <= '0;
      end else if (we_i && in_debug_i && addr_i == (ADDR_SCR0 + 12'(g))) begin
        scr_q <= wdata_i;
      end
    end
    assign scratch_o[g] = scr_q;
  end

  assign rpc_o = rpc_q;

  assert_rpc_locked_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (!in_debug_i && !enter_i) |=> $stable(rpc_q));
endmodule

// File: rtl/hart_debug_csr_unit.sv
module hart_debug_csr_unit
  import dbgcsr_pkg::*;
#(
  parameter int XLEN          = 32,
  parameter int SCRATCH_COUNT = 1
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [11:0]     csr_addr_i,
  input  logic            csr_we_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  input  logic [XLEN-1:0] pc_i,
  input  logic [1:0]      priv_i,
  input  logic            halt_req_i,
  input  logic            brk_exec_i,
  input  logic            retire_i,
  input  logic            dbg_return_i,
  output logic            dbg_mode_o,
  output logic            redirect_valid_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic [1:0]      restore_priv_o
);
  localparam int SCR_LAST = SCRATCH_COUNT - 1;

  logic                               mode_q;
  logic                               enter;
  cause_e                             enter_cause;
  ctrl_t                              ctrl;
  logic [XLEN-1:0]                    ctrl_word;
  logic [XLEN-1:0]                    rpc;
  logic [SCRATCH_COUNT-1:0][XLEN-1:0] scratch;
  logic [XLEN-1:0]                    rd_next;
  logic                               redir_v_q;
  logic [XLEN-1:0]                    redir_pc_q;
  logic [1:0]                         redir_priv_q;
  logic [XLEN-1:0]                    rdata_q;

  dbg_entry_arb u_arb (
    .in_debug_i (mode_q),
    .priv_i     (legal_priv(priv_i)),
    .brk_i      (brk_exec_i),
    .halt_i     (halt_req_i),
    .retire_i   (retire_i),
    .step_en_i  (ctrl.step),
    .brk_en_m_i (ctrl.brk_m),
    .brk_en_s_i (ctrl.brk_s),
    .brk_en_u_i (ctrl.brk_u),
    .enter_o    (enter),
    .cause_o    (enter_cause)
  );

  dbg_ctrl_reg #(.XLEN(XLEN)) u_ctrl (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .in_debug_i (mode_q),
    .wr_i       (csr_we_i && csr_addr_i == ADDR_CTRL),
    .wdata_i    (csr_wdata_i),
    .enter_i    (enter),
    .cause_i    (enter_cause),
    .priv_i     (priv_i),
    .ctrl_o     (ctrl),
    .word_o     (ctrl_word)
  );

  dbg_pc_store #(.XLEN(XLEN), .SCRATCH_COUNT(SCRATCH_COUNT)) u_store (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .in_debug_i (mode_q),
    .enter_i    (enter),
    .pc_i       (pc_i),
    .we_i       (csr_we_i),
    .addr_i     (csr_addr_i),
    .wdata_i    (csr_wdata_i),
    .rpc_o      (rpc),
    .scratch_o  (scratch)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q       <= 1'b0;
      redir_v_q    <= 1'b0;
      redir_pc_q   <= '0;
      redir_priv_q <= PRIV_M;
    end else begin
      redir_v_q <= 1'b0;
      if (enter) begin
        mode_q <= 1'b1;
      end else if (dbg_return_i && mode_q) begin
        mode_q       <= 1'b0;
        redir_v_q    <= 1'b1;
        redir_pc_q   <= rpc;
        redir_priv_q <= ctrl.prv;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (csr_addr_i == ADDR_CTRL) begin
      rd_next = ctrl_word;
    end else if (csr_addr_i == ADDR_RPC) begin
      rd_next = rpc;
    end else begin
      for (int i = 0; i <= SCR_LAST; i++) begin
        if (csr_addr_i == (ADDR_SCR0 + 12'(i))) rd_next = scratch[i];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_q <= '0;
    else       rdata_q <= rd_next;
  end

  assign dbg_mode_o       = mode_q;
  assign redirect_valid_o = redir_v_q;
  assign redirect_pc_o    = redir_pc_q;
  assign restore_priv_o   = redir_priv_q;
  assign csr_rdata_o      = rdata_q;

  assert_halt_enters_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (!mode_q && halt_req_i) |=> mode_q);

  assert_redirect_pulse_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    redir_v_q |=> !redir_v_q);

  assert_redirect_exits_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    redir_v_q |-> (!mode_q && $past(mode_q)));

  assert_no_redirect_idle_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    (!mode_q && !enter) |=> !redir_v_q);
endmodule

// File: tb/hart_debug_csr_unit_bench.sv
module hart_debug_csr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pc = '0;
  logic [1:0]  priv = 2'd3;
  logic        halt = 1'b0, brk = 1'b0, ret = 1'b0, retire = 1'b0;
  logic        dmode, rvalid;
  logic [31:0] rpc;
  logic [1:0]  rpriv;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hart_debug_csr_unit u_hart_debug_csr_unit (
    .clk_i(clk), .rst_i(rst), .csr_addr_i(addr), .csr_we_i(we),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .pc_i(pc), .priv_i(priv),
    .halt_req_i(halt), .brk_exec_i(brk), .retire_i(retire),
    .dbg_return_i(ret), .dbg_mode_o(dmode), .redirect_valid_o(rvalid),
    .redirect_pc_o(rpc), .restore_priv_o(rpriv)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    @(negedge clk);
    check(tag, rdata, exp);
  endtask

  task automatic pulse(input logic h, input logic b, input logic r,
                       input logic [31:0] p, input logic [1:0] pv);
    halt = h; brk = b; retire = r; pc = p; priv = pv;
    @(negedge clk);
    halt = 1'b0; brk = 1'b0; retire = 1'b0;
  endtask

  task automatic do_return(input string tag, input logic [31:0] exp_pc, input logic [1:0] exp_pv);
    ret = 1'b1;
    @(negedge clk);
    ret = 1'b0;
    check({tag, " redirect valid"}, 32'(rvalid), 32'd1);
    check({tag, " redirect pc"}, rpc, exp_pc);
    check({tag, " restore priv"}, 32'(rpriv), 32'(exp_pv));
    check({tag, " left debug"}, 32'(dmode), 32'd0);
    @(negedge clk);
    check({tag, " redirect one cycle"}, 32'(rvalid), 32'd0);
  endtask

  task automatic t_reset;
    check("R1 mode", 32'(dmode), 32'd0);
    check("R1 redirect", 32'(rvalid), 32'd0);
    rd_check("R1 ctrl", 12'h7B0, 32'h4000_0003);
    rd_check("R1 rpc", 12'h7B1, 32'h0);
    rd_check("R1 scratch", 12'h7B2, 32'h0);
    rd_check("R2 unmapped 7B3", 12'h7B3, 32'h0);
    rd_check("R2 unmapped 300", 12'h300, 32'h0);
  endtask

  task automatic t_ctrl_write;
    wr(12'h7B0, 32'hFFFF_FFFF);
    rd_check("R3 all ones", 12'h7B0, 32'h4000_BE17);
    wr(12'h7B0, 32'h0000_0002);
    rd_check("R4 reserved priv", 12'h7B0, 32'h4000_0003);
  endtask

  task automatic t_locked_outside;
    wr(12'h7B1, 32'h55);
    wr(12'h7B2, 32'h66);
    rd_check("R10 rpc locked", 12'h7B1, 32'h0);
    rd_check("R10 scratch locked", 12'h7B2, 32'h0);
  endtask

  task automatic t_halt_entry;
    pulse(1'b1, 1'b0, 1'b0, 32'h1000, 2'd0);
    check("R5 mode", 32'(dmode), 32'd1);
    rd_check("R5 ctrl cause3 prv0", 12'h7B0, 32'h4000_00C0);
    rd_check("R5 rpc", 12'h7B1, 32'h1000);
  endtask

  task automatic t_ignored_in_debug;
    pulse(1'b1, 1'b1, 1'b1, 32'h2000, 2'd3);
    check("R9 mode", 32'(dmode), 32'd1);
    rd_check("R9 rpc kept", 12'h7B1, 32'h1000);
    rd_check("R9 ctrl kept", 12'h7B0, 32'h4000_00C0);
  endtask

  task automatic t_write_in_debug;
    wr(12'h7B1, 32'h3000);
    wr(12'h7B2, 32'hABCD);
    rd_check("R10 rpc written", 12'h7B1, 32'h3000);
    rd_check("R10 scratch written", 12'h7B2, 32'hABCD);
  endtask

  task automatic t_return;
    do_return("R11", 32'h3000, 2'd0);
    ret = 1'b1;
    @(negedge clk);
    ret = 1'b0;
    check("R11 idle return no redirect", 32'(rvalid), 32'd0);
    check("R11 idle return mode", 32'(dmode), 32'd0);
  endtask

  task automatic t_brk;
    pulse(1'b0, 1'b1, 1'b0, 32'h3C, 2'd0);
    check("R6 disabled brk", 32'(dmode), 32'd0);
    wr(12'h7B0, 32'h0000_1000);
    pulse(1'b0, 1'b1, 1'b0, 32'h40, 2'd0);
    check("R6 enabled brk", 32'(dmode), 32'd1);
    rd_check("R6 ctrl cause1", 12'h7B0, 32'h4000_1040);
    rd_check("R6 rpc", 12'h7B1, 32'h40);
    do_return("R6", 32'h40, 2'd0);
  endtask

  task automatic t_step;
    wr(12'h7B0, 32'h0000_0004);
    pulse(1'b0, 1'b0, 1'b1, 32'h44, 2'd0);
    check("R8 step mode", 32'(dmode), 32'd1);
    rd_check("R8 ctrl cause4", 12'h7B0, 32'h4000_0104);
    rd_check("R8 rpc", 12'h7B1, 32'h44);
    do_return("R8", 32'h44, 2'd0);
  endtask

  task automatic t_priority;
    wr(12'h7B0, 32'h0000_8004);
    pulse(1'b1, 1'b1, 1'b1, 32'h80, 2'd3);
    rd_check("R7 brk wins", 12'h7B0, 32'h4000_8047);
    do_return("R7 a", 32'h80, 2'd3);
    pulse(1'b1, 1'b0, 1'b1, 32'h90, 2'd3);
    rd_check("R7 halt over step", 12'h7B0, 32'h4000_80C7);
    rd_check("R7 rpc", 12'h7B1, 32'h90);
    do_return("R7 b", 32'h90, 2'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl_write();
    t_locked_outside();
    t_halt_entry();
    t_ignored_in_debug();
    t_write_in_debug();
    t_return();
    t_brk();
    t_step();
    t_priority();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule